// File: doc/BRIEF.md
# Raster-Op Block Transfer Engine

This engine fills a rectangle of destination pixels from three operands: a source pixel, a pixel of an 8x8 pattern tile, and the pixel already in the destination. The three operands are combined bit by bit through one of the 256 possible three-input boolean functions, chosen by an 8-bit code. The result goes back to the destination. Each memory word holds one pixel, and pixels can be 8, 16 or 32 bits wide. The source can also be a monochrome bitmap, where each bit selects either a foreground color or a background color.

Software programs the geometry, the function code, the colors and the mode through a small write-only register port. Software then writes the start register. The engine reads and writes memory on its own and raises a completion flag and an interrupt pulse at the end. In transparent mode, a destination pixel is written or kept depending on whether it matches a key color. When the source and destination rectangles overlap, the engine picks the walk direction so that the result is the same as reading every source pixel before any write.

Top module: `blt_engine`

## Requirements
- R1: For each bit i of the pixel, the result bit is `rop[4*P[i] + 2*S[i] + D[i]]`, where P, S and D are the pattern, source and destination bits.
- R2: The pixel-size field is 0 for 8 bpp, 1 for 16 bpp and 2 for 32 bpp. Operands and the key compare use only the low pixel-size bits. Written data has zeros above the pixel width.
- R3: The pattern pixel for rectangle position (x, y) is read from `pat_base + 8*(y mod 8) + (x mod 8)`. Here x and y are counted from the rectangle's top-left corner.
- R4: In monochrome mode, the source bit for (x, y) is bit `x mod 32` of the word at `src_base + y*src_pitch + x/32`. A 1 bit selects the foreground color and a 0 bit selects the background color.
- R5: In opaque mode, every pixel of the `width` x `height` destination rectangle (`dst_base + y*dst_pitch + x`) is written, and no word outside the rectangle changes.
- R6: In transparent mode with select 0, a pixel is written only where the masked destination equals the masked key. With select 1, a pixel is written only where they differ. Skipped pixels keep their old value.
- R7: With a color source and `dst_base > src_base`, the walk runs from the last row and last column backwards. Otherwise it runs forward. In both cases the result equals a transfer that uses the source contents from before the start.
- R8: `busy` rises on the edge that accepts the start write and stays high until the last pixel is done. `done` is then set and `irq` is high for exactly one cycle. `done` clears on the next start.
- R9: Any register write while `busy` is high, including a start, is ignored. It affects neither the running transfer nor later ones.
- R10: After reset, `busy`, `done`, `irq` and `mem_req` are 0.
- R11: Register addresses are: 0 source base, 1 destination base, 2 pattern base, 3 source pitch, 4 destination pitch, 5 width, 6 height, 7 raster-op code, 8 foreground, 9 background, 10 key, 11 mode, 15 start. The mode register holds bits [1:0] pixel size, bit 2 monochrome, bit 3 transparent and bit 4 transparent select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | DW | Register write data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (with mem_req) |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Read data, valid one cycle after a read request |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last transfer finished |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The assertions take several things for granted about the inputs:
- Width and height are at least 1 whenever a start is accepted.
- The memory returns read data exactly one cycle after each read request and never stalls.
- The register inputs stay at rest while no write strobe is present.

The stimulus respects these assumptions in the following ways:
- Random sizes are drawn from 1 upwards.
- The bench memory model answers every request on the next edge.
- Pattern, source and destination areas are placed so that only the deliberate overlap cases share words.

// File: rtl/blt_pkg.sv
package blt_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RSRC,
      ST_RPAT,
      ST_RDST,
      ST_WR
   } blt_state_e;

   localparam logic [3:0] RA_SRC   = 4'd0;
   localparam logic [3:0] RA_DST   = 4'd1;
   localparam logic [3:0] RA_PAT   = 4'd2;
   localparam logic [3:0] RA_SPIT  = 4'd3;
   localparam logic [3:0] RA_DPIT  = 4'd4;
   localparam logic [3:0] RA_WID   = 4'd5;
   localparam logic [3:0] RA_HGT   = 4'd6;
   localparam logic [3:0] RA_ROP   = 4'd7;
   localparam logic [3:0] RA_FG    = 4'd8;
   localparam logic [3:0] RA_BG    = 4'd9;
   localparam logic [3:0] RA_KEY   = 4'd10;
   localparam logic [3:0] RA_MODE  = 4'd11;
   localparam logic [3:0] RA_GO    = 4'd15;

   localparam logic [1:0] BPP8  = 2'd0;
   localparam logic [1:0] BPP16 = 2'd1;
endpackage

// File: rtl/blt_rop.sv
module blt_rop #(
   parameter int DW = 32
) (
   input  logic [7:0]    rop,
   input  logic [DW-1:0] p,
   input  logic [DW-1:0] s,
   input  logic [DW-1:0] d,
   output logic [DW-1:0] r
);
   // one 8:1 selector per bit, indexed by the three operand bits
   for (genvar i = 0; i < DW; i++) begin : g_bit
      assign r[i] = rop[{p[i], s[i], d[i]}];
   end
endmodule

// File: rtl/blt_expand.sv
module blt_expand #(
   parameter int DW = 32
) (
   input  logic          mono,
   input  logic          bit_sel,
   input  logic [DW-1:0] raw,
   input  logic [DW-1:0] fg,
   input  logic [DW-1:0] bg,
   input  logic [DW-1:0] mask,
   output logic [DW-1:0] pix
);
   logic [DW-1:0] color;
   assign color = bit_sel ? fg : bg;
   assign pix   = (mono ? color : raw) & mask;
endmodule

// File: rtl/blt_walker.sv
module blt_walker #(
   parameter int CW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          step,
   input  logic          rev_in,
   input  logic [CW-1:0] w,
   input  logic [CW-1:0] h,
   output logic [CW-1:0] x,
   output logic [CW-1:0] y,
   output logic          last
);
   logic          rev_q;
   logic [CW-1:0] w_q, h_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rev_q <= 1'b0;
         w_q   <= '0;
         h_q   <= '0;
         x     <= '0;
         y     <= '0;
      end else if (load) begin
         rev_q <= rev_in;
         w_q   <= w;
         h_q   <= h;
         x     <= rev_in ? w - 1'b1 : '0;
         y     <= rev_in ? h - 1'b1 : '0;
      end else if (step) begin
         if (rev_q) begin
            if (x == '0) begin
               x <= w_q - 1'b1;
               y <= y - 1'b1;
            end else begin
               x <= x - 1'b1;
            end
         end else begin
            if (x == w_q - 1'b1) begin
               x <= '0;
               y <= y + 1'b1;
            end else begin
               x <= x + 1'b1;
            end
         end
      end
   end

   assign last = rev_q ? (x == '0 && y == '0)
                       : (x == w_q - 1'b1 && y == h_q - 1'b1);

   AST_STEP_IN_RECT: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> (x < w_q && y < h_q)); // R7
endmodule

// File: rtl/blt_engine.sv
module blt_engine
   import blt_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 32,
   parameter int CW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [3:0]    reg_addr,
   input  logic [DW-1:0] reg_wdata,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   output logic          busy,
   output logic          done,
   output logic          irq
);
   localparam int XSH = $clog2(DW);

   if (DW < 32 || (1 << XSH) != DW) begin : g_chk_dw
      $error("blt_engine: DW must be a power of two of at least 32");
   end
   if (AW > DW || CW > AW || CW < XSH) begin : g_chk_w
      $error("blt_engine: need XSH <= CW <= AW <= DW");
   end

   logic [AW-1:0] src_base_q, dst_base_q, pat_base_q, src_pit_q, dst_pit_q;
   logic [CW-1:0] wid_q, hgt_q;
   logic [7:0]    rop_q;
   logic [DW-1:0] fg_q, bg_q, key_q;
   logic [1:0]    bpp_q;
   logic          mono_q, trans_q, tsel_q;
   blt_state_e    st_q;
   logic [DW-1:0] src_q, pat_q;

   logic          go, adv, last, rev, wr_ok, hit;
   logic [CW-1:0] x, y;
   logic [DW-1:0] mask, s_pix, p_pix, d_pix, r_raw, res;
   logic [AW-1:0] src_addr, pat_addr, dst_addr;

   assign busy = (st_q != ST_IDLE);
   assign go   = reg_we && !busy && reg_addr == RA_GO;
   assign rev  = !mono_q && (dst_base_q > src_base_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_base_q <= '0; dst_base_q <= '0; pat_base_q <= '0;
         src_pit_q  <= '0; dst_pit_q  <= '0;
         wid_q <= '0; hgt_q <= '0; rop_q <= '0;
         fg_q <= '0; bg_q <= '0; key_q <= '0;
         bpp_q <= '0; mono_q <= 1'b0; trans_q <= 1'b0; tsel_q <= 1'b0;
      end else if (reg_we && !busy) begin
         case (reg_addr)
            RA_SRC:  src_base_q <= reg_wdata[AW-1:0];
            RA_DST:  dst_base_q <= reg_wdata[AW-1:0];
            RA_PAT:  pat_base_q <= reg_wdata[AW-1:0];
            RA_SPIT: src_pit_q  <= reg_wdata[AW-1:0];
            RA_DPIT: dst_pit_q  <= reg_wdata[AW-1:0];
            RA_WID:  wid_q      <= reg_wdata[CW-1:0];
            RA_HGT:  hgt_q      <= reg_wdata[CW-1:0];
            RA_ROP:  rop_q      <= reg_wdata[7:0];
            RA_FG:   fg_q       <= reg_wdata;
            RA_BG:   bg_q       <= reg_wdata;
            RA_KEY:  key_q      <= reg_wdata;
            RA_MODE: begin
               bpp_q   <= reg_wdata[1:0];
               mono_q  <= reg_wdata[2];
               trans_q <= reg_wdata[3];
               tsel_q  <= reg_wdata[4];
            end
            default: ;
         endcase
      end
   end

   blt_walker #(.CW(CW)) u_walk (
      .clk(clk), .rst_n(rst_n), .load(go), .step(adv), .rev_in(rev),
      .w(wid_q), .h(hgt_q), .x(x), .y(y), .last(last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         done  <= 1'b0;
         irq   <= 1'b0;
         src_q <= '0;
         pat_q <= '0;
      end else begin
         irq <= 1'b0;
         case (st_q)
            ST_IDLE: if (go) begin
               st_q <= ST_RSRC;
               done <= 1'b0;
            end
            ST_RSRC: st_q <= ST_RPAT;
            ST_RPAT: begin
               src_q <= mem_rdata;
               st_q  <= ST_RDST;
            end
            ST_RDST: begin
               pat_q <= mem_rdata;
               st_q  <= ST_WR;
            end
            ST_WR: begin
               if (last) begin
                  st_q <= ST_IDLE;
                  done <= 1'b1;
                  irq  <= 1'b1;
               end else begin
                  st_q <= ST_RSRC;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end
   assign adv = (st_q == ST_WR) && !last;

   always_comb begin
      case (bpp_q)
         BPP8:    mask = DW'(8'hFF);
         BPP16:   mask = DW'(16'hFFFF);
         default: mask = DW'(32'hFFFF_FFFF);
      endcase
   end

   assign src_addr = src_base_q + AW'(y) * src_pit_q
                   + (mono_q ? AW'(x >> XSH) : AW'(x));
   assign pat_addr = pat_base_q + AW'({y[2:0], x[2:0]});
   assign dst_addr = dst_base_q + AW'(y) * dst_pit_q + AW'(x);

   blt_expand #(.DW(DW)) u_exp (
      .mono(mono_q), .bit_sel(src_q[x[XSH-1:0]]), .raw(src_q),
      .fg(fg_q), .bg(bg_q), .mask(mask), .pix(s_pix)
   );

   assign p_pix = pat_q & mask;
   assign d_pix = mem_rdata & mask;

   blt_rop #(.DW(DW)) u_rop (
      .rop(rop_q), .p(p_pix), .s(s_pix), .d(d_pix), .r(r_raw)
   );

   assign res   = r_raw & mask;
   assign hit   = (d_pix == (key_q & mask));
   assign wr_ok = !trans_q || (tsel_q ? !hit : hit);

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = dst_addr;
      mem_wdata = res;
      case (st_q)
         ST_RSRC: begin mem_req = 1'b1; mem_addr = src_addr; end
         ST_RPAT: begin mem_req = 1'b1; mem_addr = pat_addr; end
         ST_RDST: mem_req = 1'b1;
         ST_WR:   begin mem_req = wr_ok; mem_we = wr_ok; end
         default: ;
      endcase
   end

   AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq); // R8
   AST_IRQ_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (done && !busy)); // R8
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req); // R10
   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(rop_q) && $stable(dst_base_q))); // R9
   AST_KEY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && trans_q) |-> (tsel_q ^ (((mem_rdata ^ key_q) & mask) == '0))); // R6
   AST_WDATA_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> ((mem_wdata & ~mask) == '0)); // R2
endmodule

// File: tb/sim_blt_engine.sv
module sim_blt_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic        mem_req, mem_we, busy, done, irq;
   logic [15:0] mem_addr;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata = '0;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   int irq_cnt = 0;

   logic [31:0] mem  [4096];
   logic [31:0] snap [4096];
   logic [31:0] expv [4096];

   int b_src, b_dst, b_pat, b_sp, b_dp, b_w, b_h;
   logic [7:0]  b_rop;
   logic [31:0] b_fg, b_bg, b_key, b_mode;

   always #2.5 clk = ~clk;

   blt_engine u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .busy(busy), .done(done), .irq(irq)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (irq) irq_cnt <= irq_cnt + 1;
      if (mem_req) begin
         if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
         else        mem_rdata <= mem[mem_addr[11:0]];
      end
   end

   always @(posedge clk) begin
      if (cycles > 190000) begin
         errors = errors + 1;
         checks = checks + 1;
         $display("FAIL watchdog: run did not finish, actual=%0d cycles expected<190000", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   // R11: register map
   task automatic setup(input int src, input int dst, input int pat, input int sp,
                        input int dp, input int w, input int h, input logic [7:0] rop,
                        input logic [31:0] fg, input logic [31:0] bg,
                        input logic [31:0] key, input logic [31:0] mode);
      b_src = src; b_dst = dst; b_pat = pat; b_sp = sp; b_dp = dp;
      b_w = w; b_h = h; b_rop = rop; b_fg = fg; b_bg = bg; b_key = key; b_mode = mode;
      wr(4'd0, src); wr(4'd1, dst); wr(4'd2, pat); wr(4'd3, sp); wr(4'd4, dp);
      wr(4'd5, w); wr(4'd6, h); wr(4'd7, {24'd0, rop}); wr(4'd8, fg);
      wr(4'd9, bg); wr(4'd10, key); wr(4'd11, mode);
   endtask

   task automatic fill_rand();
      for (int i = 0; i < 4096; i++) mem[i] = $urandom;
   endtask

   task automatic start_op();
      for (int i = 0; i < 4096; i++) snap[i] = mem[i];
      irq_cnt = 0;
      wr(4'd15, 32'd1);
      chk("R8 busy after start", {31'd0, busy}, 32'd1);
   endtask

   task automatic wait_end();
      int t = 0;
      while (busy && t < 20000) begin
         @(negedge clk);
         t++;
      end
      @(negedge clk);
      chk("R8 done set", {31'd0, done}, 32'd1);
      chk("R8 one irq pulse", irq_cnt, 32'd1);
   endtask

   function automatic logic [31:0] pmask();
      case (b_mode[1:0])
         2'd0:    return 32'h0000_00FF;
         2'd1:    return 32'h0000_FFFF;
         default: return 32'hFFFF_FFFF;
      endcase
   endfunction

   function automatic logic [31:0] ref_pix(input int x, input int y);
      logic [31:0] m, s, p, d, r, w0;
      logic        hit, wok;
      m = pmask();
      if (b_mode[2]) begin
         w0 = snap[(b_src + y * b_sp + x / 32) % 4096];
         s  = (w0[x % 32] ? b_fg : b_bg) & m;
      end else begin
         s = snap[(b_src + y * b_sp + x) % 4096] & m;
      end
      p = snap[(b_pat + 8 * (y % 8) + (x % 8)) % 4096] & m;
      d = snap[(b_dst + y * b_dp + x) % 4096] & m;
      for (int i = 0; i < 32; i++) r[i] = b_rop[{p[i], s[i], d[i]}];
      r   = r & m;
      hit = (d == (b_key & m));
      wok = !b_mode[3] || (b_mode[4] ? !hit : hit);
      return wok ? r : snap[(b_dst + y * b_dp + x) % 4096];
   endfunction

   task automatic verify(input string req);
      int bad = 0;
      int first = -1;
      for (int i = 0; i < 4096; i++) expv[i] = snap[i];
      for (int y = 0; y < b_h; y++)
         for (int x = 0; x < b_w; x++)
            expv[(b_dst + y * b_dp + x) % 4096] = ref_pix(x, y);
      for (int i = 0; i < 4096; i++)
         if (mem[i] !== expv[i]) begin
            if (first < 0) first = i;
            bad++;
         end
      checks = checks + 1;
      if (bad != 0) begin
         errors = errors + 1;
         $display("FAIL %s: %0d words wrong, first at %0d actual=%h expected=%h",
                  req, bad, first, mem[first], expv[first]);
      end
   endtask

   task automatic blit(input string req);
      start_op();
      wait_end();
      verify(req);
   endtask

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < 4096; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      chk("R10 busy reset", {31'd0, busy}, 32'd0);
      chk("R10 done reset", {31'd0, done}, 32'd0);
      chk("R10 irq reset", {31'd0, irq}, 32'd0);
      chk("R10 mem_req reset", {31'd0, mem_req}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R5: plain source copy, 32 bpp
      fill_rand();
      setup(256, 2048, 0, 24, 32, 13, 7, 8'hCC, 0, 0, 0, 32'd2);
      blit("R1 R5 source copy");

      // R3 R2: pattern only, 8 bpp, sizes off the tile grid
      fill_rand();
      setup(256, 2048, 0, 24, 32, 11, 10, 8'hF0, 0, 0, 0, 32'd0);
      blit("R3 R2 pattern tiling 8bpp");

      // R1 R2: random function codes and pixel sizes
      for (int k = 0; k < 8; k++) begin
         fill_rand();
         setup(256, 2048, 0, 24, 32, 1 + $urandom % 20, 1 + $urandom % 12,
               8'($urandom), 0, 0, 0, 32'($urandom % 3));
         blit("R1 R2 random rop");
      end

      // R4: monochrome expansion at 16 bpp, two words per row
      fill_rand();
      setup(256, 2048, 0, 2, 64, 40, 6, 8'hCC, 32'h1234_ABCD, 32'h0000_5A5A, 0, 32'h4 | 32'd1);
      blit("R4 mono expand");

      // R4 R1: monochrome mixed with pattern and destination, 32 bpp
      fill_rand();
      setup(256, 2048, 0, 1, 32, 32, 5, 8'h96, 32'hFFFF_0000, 32'h00FF_00FF, 0, 32'h4 | 32'd2);
      blit("R4 R1 mono with rop");

      // R6: transparent, write where equal, 8 bpp with noisy high bits
      fill_rand();
      for (int i = 0; i < 300; i += 3) mem[2048 + i] = {24'($urandom), 8'h3C};
      setup(256, 2048, 0, 24, 32, 9, 9, 8'hCC, 0, 0, 32'h0000_003C, 32'h8 | 32'd0);
      blit("R6 transparent equal");

      // R6: transparent, write where different, 32 bpp
      fill_rand();
      for (int i = 0; i < 300; i += 2) mem[2048 + i] = 32'hDEAD_BEEF;
      setup(256, 2048, 0, 24, 32, 9, 9, 8'h33, 0, 0, 32'hDEAD_BEEF, 32'h18 | 32'd2);
      blit("R6 transparent differ");

      // R7: overlap, destination after source
      fill_rand();
      setup(1024, 1024 + 32 + 3, 0, 32, 32, 20, 8, 8'hCC, 0, 0, 0, 32'd2);
      blit("R7 overlap backward");

      // R7: overlap, destination before source
      fill_rand();
      setup(1024 + 32 + 3, 1024, 0, 32, 32, 20, 8, 8'hCC, 0, 0, 0, 32'd2);
      blit("R7 overlap forward");

      // R9: writes during a transfer are ignored
      fill_rand();
      setup(256, 2048, 0, 24, 32, 12, 6, 8'hCC, 0, 0, 0, 32'd2);
      start_op();
      wr(4'd7, 32'h0000_0000);
      wr(4'd1, 32'd3000);
      wr(4'd15, 32'd1);
      wait_end();
      verify("R9 busy writes ignored");
      chk("R9 still idle after end", {31'd0, busy}, 32'd0);
      fill_rand();
      blit("R9 registers kept");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule